// File: doc/BRIEF.md
# Fetch-Paced Refresh Address Generator

This block sits next to a simple CPU bus sequencer and supplies the memory refresh cycle that follows each opcode fetch. It holds a 7-bit row counter. Each fetch advances the counter by one. In the clock cycle after a fetch, the block raises a refresh strobe and takes the address bus. It then drives the counter onto the low address bits, with every upper bit held at zero. The data bus enable stays low for the whole refresh cycle, so every memory device can refresh the same row at once without a data collision.

When the sequencer requests a halt, the block starts a loop of its own. It issues a virtual no-operation fetch, then a refresh, and repeats. Refresh therefore keeps running while the CPU is stopped, and a halt always spans a whole number of fetch/refresh pairs. A resume or interrupt input ends the loop, and the exit happens only at the end of a refresh cycle. Software can read the counter at any time through a register port and can overwrite it.

Top module: `rfsh_gen`

## Requirements
- R1: After reset the counter reads 0, the block is in run mode, and the following outputs are all low: fetch indication, refresh strobe, bus ownership, halt acknowledge, dummy fetch and data enable. The address output is 0.
- R2: In run mode, when `fetchReq` is high in a cycle that is not a refresh cycle, `fetchCycle` is high in that same cycle and the counter increments by one at the end of it.
- R3: The cycle after every fetch cycle, whether real or dummy, is a refresh cycle. During it `rfshStrobe` and `busOwn` are both high. Neither is high in any other cycle.
- R4: During a refresh cycle, `addrOut[6:0]` equals the counter value held in that cycle and `addrOut[15:7]` is 0. Outside refresh cycles, `addrOut` is 0.
- R5: `dataBusEn` is high exactly in fetch cycles and is never high together with `rfshStrobe`.
- R6: A `fetchReq` that arrives during a refresh cycle is ignored. No fetch is indicated and the counter does not change.
- R7: The counter wraps from 127 to 0 on a fetch.
- R8: `regRdData` always shows the counter. When `regWrEn` is high, the counter takes `regWrData` at the end of that cycle. A write takes priority over an increment in the same cycle, and the next fetch counts up from the written value.
- R9: In run mode, `haltReq` enters the halt loop after the current cycle. A `fetchReq` in the same cycle takes precedence. If `haltReq` arrives during a refresh cycle, the next cycle is the first dummy fetch. In the halt loop, `haltAck` is high and cycles alternate: a dummy fetch (`dummyFetch` and `fetchCycle` high, counter increments), then a refresh.
- R10: `resumeReq` ends the halt loop only at the end of a halt refresh cycle. A resume seen during a dummy fetch is remembered. `fetchReq` has no effect while the block is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Sequencer requests an opcode fetch this cycle |
| haltReq | input | 1 | Request to enter the halt loop |
| resumeReq | input | 1 | Resume or interrupt, ends the halt loop |
| regWrEn | input | 1 | Counter write strobe |
| regWrData | input | 7 | Value to load into the counter |
| regRdData | output | 7 | Current counter value |
| fetchCycle | output | 1 | This cycle is a fetch (real or dummy) |
| dummyFetch | output | 1 | This cycle is a virtual no-operation fetch |
| haltAck | output | 1 | Block is in the halt loop |
| rfshStrobe | output | 1 | Refresh cycle indication to memories |
| busOwn | output | 1 | Other masters must release the address bus |
| addrOut | output | 16 | Address driven during refresh, 0 otherwise |
| dataBusEn | output | 1 | Data bus enable, fetch cycles only |

## Verification
The embedded assertions check, on every clock, these fixed relationships:
- a refresh always follows a fetch;
- the data enable never overlaps the strobe;
- the refresh address carries the counter;
- an increment adds exactly one and a write lands exactly;
- a dummy fetch is followed by a halted refresh;
- the halt loop is left only after a refresh.

Only the bench scenarios can show the following behaviour:
- the counter wraps at the right fetch;
- a fetch requested during a refresh is dropped;
- a resume that arrives during a dummy fetch is held until the refresh ends;
- a halt and a fetch requested together resolve in favour of the fetch.

The bench follows both of these against a behavioural model on every cycle.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_RFSH = 2'd1,
    ST_HFET = 2'd2,
    ST_HRFS = 2'd3
  } rfshState_e;

  typedef struct packed {
    logic incCnt;
    logic rfsh;
  } rfshCtl_t;
endpackage

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     fetchReq,
  input  logic     haltReq,
  input  logic     resumeReq,
  output rfshCtl_t ctl,
  output logic     fetchCycle,
  output logic     dummyFetch,
  output logic     haltAck
);
  rfshState_e state, stateNext;
  logic resumePend, resumePendNext, exitHalt;

  assign exitHalt = (state == ST_HRFS) && (resumeReq || resumePend);

  always_comb begin
    fetchCycle = ((state == ST_RUN) && fetchReq) || (state == ST_HFET);
    dummyFetch = (state == ST_HFET);
    haltAck    = (state == ST_HFET) || (state == ST_HRFS);
    ctl.incCnt = fetchCycle;
    ctl.rfsh   = (state == ST_RFSH) || (state == ST_HRFS);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:  stateNext = fetchReq ? ST_RFSH : (haltReq ? ST_HFET : ST_RUN);
      ST_RFSH: stateNext = haltReq ? ST_HFET : ST_RUN;
      ST_HFET: stateNext = ST_HRFS;
      ST_HRFS: stateNext = exitHalt ? ST_RUN : ST_HFET;
      default: stateNext = ST_RUN;
    endcase
  end

  always_comb begin
    resumePendNext = 1'b0;
    if (haltAck && !exitHalt) resumePendNext = resumePend || resumeReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_RUN;
      resumePend <= 1'b0;
    end else begin
      state      <= stateNext;
      resumePend <= resumePendNext;
    end
  end

  a_r3_rfsh_after_fetch: assert property (@(posedge clk) disable iff (!rstN)
    fetchCycle |=> ctl.rfsh);
  a_r5_no_data_in_rfsh: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchCycle && ctl.rfsh));
  a_r9_dummy_then_rfsh: assert property (@(posedge clk) disable iff (!rstN)
    dummyFetch |=> (ctl.rfsh && haltAck));
  a_r10_exit_after_rfsh: assert property (@(posedge clk) disable iff (!rstN)
    $fell(haltAck) |-> $past(ctl.rfsh));
endmodule

// File: rtl/rfsh_dpath.sv
module rfsh_dpath
  import rfsh_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfshCtl_t          ctl,
  input  logic              wrEn,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int UPPER_W = ADDR_W - CNT_W;

  always_ff @(posedge clk) begin
    if (!rstN)           cnt <= '0;
    else if (wrEn)       cnt <= wrData;
    else if (ctl.incCnt) cnt <= cnt + 1'b1;
  end

  generate
    if (UPPER_W > 0) begin : g_pad
      assign addrOut = ctl.rfsh ? {{UPPER_W{1'b0}}, cnt} : '0;
    end else begin : g_nopad
      assign addrOut = ctl.rfsh ? cnt[ADDR_W-1:0] : '0;
    end
  endgenerate

  a_r2_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.incCnt && !wrEn) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> cnt == $past(wrData));
  a_r4_addr_carries_cnt: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rfsh |-> addrOut[CNT_W-1:0] == cnt);
endmodule

// File: rtl/rfsh_gen.sv
module rfsh_gen
  import rfsh_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic              haltReq,
  input  logic              resumeReq,
  input  logic              regWrEn,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  output logic              fetchCycle,
  output logic              dummyFetch,
  output logic              haltAck,
  output logic              rfshStrobe,
  output logic              busOwn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              dataBusEn
);
  rfshCtl_t ctl;

  rfsh_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .haltReq(haltReq),
    .resumeReq(resumeReq), .ctl(ctl), .fetchCycle(fetchCycle),
    .dummyFetch(dummyFetch), .haltAck(haltAck)
  );

  rfsh_dpath #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrEn(regWrEn), .wrData(regWrData),
    .cnt(regRdData), .addrOut(addrOut)
  );

  assign rfshStrobe = ctl.rfsh;
  assign busOwn     = ctl.rfsh;
  assign dataBusEn  = fetchCycle;
endmodule

// File: tb/tb_rfsh_gen.sv
module tb_rfsh_gen;
  localparam int PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic fetchReq = 0, haltReq = 0, resumeReq = 0, regWrEn = 0;
  logic [6:0] regWrData = 0, regRdData;
  logic fetchCycle, dummyFetch, haltAck, rfshStrobe, busOwn, dataBusEn;
  logic [15:0] addrOut;

  int tests = 0, fails = 0;
  int mSt = 0, mCnt = 0;
  bit mPend = 0;

  always #(PERIOD/2) clk = ~clk;

  rfsh_gen dut (.*);

  task automatic chk(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit f, input bit h, input bit r, input bit we, input int wd);
    bit fe, rf;
    int nSt;
    fetchReq = f; haltReq = h; resumeReq = r; regWrEn = we; regWrData = 7'(wd);
    @(negedge clk);
    fe = (mSt == 0 && f) || mSt == 2;
    rf = (mSt == 1 || mSt == 3);
    chk(fetchCycle, fe, "R2 fetchCycle");
    chk(rfshStrobe, rf, "R3 rfshStrobe");
    chk(busOwn, rf, "R3 busOwn");
    chk(addrOut, rf ? mCnt : 0, "R4 addrOut");
    chk(dataBusEn, fe, "R5 dataBusEn");
    chk(regRdData, mCnt, "R8 regRdData");
    chk(haltAck, mSt >= 2, "R9 haltAck");
    chk(dummyFetch, mSt == 2, "R9 dummyFetch");
    case (mSt)
      0: nSt = f ? 1 : (h ? 2 : 0);
      1: nSt = h ? 2 : 0;
      2: nSt = 3;
      default: nSt = (r || mPend) ? 0 : 2;
    endcase
    if (mSt >= 2 && nSt >= 2) mPend = mPend || r; else mPend = 0;
    if (we) mCnt = wd; else if (fe) mCnt = (mCnt + 1) % 128;
    mSt = nSt;
    @(posedge clk); #1;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    chk(regRdData, 0, "R1 counter");
    chk(rfshStrobe, 0, "R1 strobe");
    chk(addrOut, 0, "R1 addr");
    chk(haltAck, 0, "R1 haltAck");
    step(0,0,0,0,0); step(0,0,0,0,0);
    // single fetch then idle
    step(1,0,0,0,0); step(0,0,0,0,0); step(0,0,0,0,0);
    // R6: fetchReq held high, request in refresh ignored
    step(1,0,0,0,0);
    step(1,0,0,0,0);
    chk(regRdData, 2, "R6 no increment in refresh");
    step(1,0,0,0,0); step(0,0,0,0,0);
    // R7 wrap
    step(0,0,0,1,126);
    step(1,0,0,0,0); step(0,0,0,0,0);
    step(1,0,0,0,0);
    chk(regRdData, 0, "R7 wrap to 0");
    step(0,0,0,0,0);
    // R8 write during fetch wins
    step(1,0,0,1,40); step(0,0,0,0,0);
    chk(regRdData, 40, "R8 write priority");
    step(1,0,0,0,0); step(0,0,0,0,0);
    // R9 halt from run, fetchReq ignored inside
    step(0,1,0,0,0);
    for (int i = 0; i < 6; i++) step(1,0,0,0,0);
    // R10 resume during dummy fetch is remembered
    step(0,0,1,0,0);
    chk(haltAck, 1, "R10 still halted in refresh");
    step(0,0,0,0,0);
    chk(haltAck, 0, "R10 exited after refresh");
    // halt during refresh, and halt with fetch together
    step(1,0,0,0,0); step(0,1,0,0,0);
    step(0,0,0,0,0); step(0,0,1,0,0);
    step(1,1,0,0,0); step(0,0,0,0,0);
    step(0,0,0,0,0); step(0,0,1,0,0); step(0,0,0,0,0);
    // mixed traffic
    for (int i = 0; i < 400; i++)
      step(($urandom % 3) != 0, ($urandom % 11) == 0, ($urandom % 4) == 0,
           ($urandom % 17) == 0, $urandom % 128);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule